// File: doc/BRIEF.md
# Multithreaded Direct-Mapped Branch Target Buffer

A small direct-mapped table that predicts the target of a taken branch. Several hardware threads share it. Each slot stores a valid flag, a partial tag taken from the PC, the number of the thread that wrote it, and a target address. The fetch stage presents a PC and a thread number and gets back a hit flag and a target in the same cycle. A resolved branch writes its slot through a separate update port.

The set is chosen from the PC bits just above the instruction offset. The thread number is XORed into the top bits of that index, so that threads running the same code use different slots. A hit also requires that the stored thread number equals the requester's thread number. A synchronous flush and the asynchronous reset both invalidate the whole table.

The entry count must be a power of two of at least 2, and the thread count must be a power of two with log2 no larger than the index width. Elaboration stops otherwise.

Top module: `mt_btb`

## Requirements
- R1: The set index is PC[INST_SHIFT +: IDX_W] XOR (thread << (IDX_W − log2(THREADS))), truncated to IDX_W bits. With the defaults (16 entries, 4 threads, INST_SHIFT=2) thread 1 flips index bit 2. Two writes that map to the same set evict each other; writes to different sets do not.
- R2: The tag is PC[INST_SHIFT+IDX_W +: TAG_W]. PC bits below INST_SHIFT and above the tag field have no effect on a lookup result.
- R3: A lookup hits only if the selected slot is valid, its tag equals the lookup tag, and its stored thread equals the lookup thread.
- R4: When `lk_hit` is 0, `lk_target` is 0.
- R5: An update overwrites the selected slot with the new tag, thread and target and marks it valid, whatever the slot held before. A lookup sees the new contents from the next cycle.
- R6: A lookup in the same cycle as an update to the same slot returns the slot's old contents.
- R7: After reset, and in the cycle after `flush` is high, every lookup misses.
- R8: When `flush` and `up_en` are high in the same cycle, the update is discarded.
- R9: A stored target of zero returns `lk_hit`=1 with `lk_target`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| flush | input | 1 | Synchronous invalidate of every slot |
| lk_pc | input | PC_W | Fetch PC for the lookup |
| lk_tid | input | TID_W | Thread making the lookup |
| lk_hit | output | 1 | Lookup found a matching slot |
| lk_target | output | TGT_W | Predicted target, zero on a miss |
| up_en | input | 1 | Write the update fields this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_tid | input | TID_W | Thread of the resolved branch |
| up_target | input | TGT_W | Resolved target |

## Verification
A corrupt index hash shows up as a missing hit on the first lookup after a write. It can also show up as a wrong eviction between threads whose indices differ only in the hashed bits. A stale valid flag after flush or reset produces a hit on the very next cycle. A tag or thread compare that is too loose produces hits for aliasing PCs or for foreign threads, and the target is then nonzero where zero is expected. Every such fault is visible at `lk_hit`/`lk_target` one cycle after the write or flush that exposes it.

// File: rtl/mt_btb.sv
module mt_btb #(
  parameter int PC_W       = 32,
  parameter int TGT_W      = 32,
  parameter int ENTRIES    = 16,
  parameter int TAG_W      = 8,
  parameter int THREADS    = 4,
  parameter int INST_SHIFT = 2,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int LOG2T     = $clog2(THREADS),
  localparam int TID_W     = (LOG2T > 0) ? LOG2T : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [TID_W-1:0] lk_tid,
  output logic             lk_hit,
  output logic [TGT_W-1:0] lk_target,
  input  logic             up_en,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [TID_W-1:0] up_tid,
  input  logic [TGT_W-1:0] up_target
);
  localparam int TAG_SHIFT = INST_SHIFT + IDX_W;
  localparam int TID_SHIFT = IDX_W - LOG2T;

  if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
    $error("mt_btb: ENTRIES must be a power of two >= 2");
  end
  if ((1 << LOG2T) != THREADS || LOG2T > IDX_W) begin : g_bad_threads
    $error("mt_btb: THREADS must be a power of two with log2 <= index width");
  end
  if (TAG_SHIFT + TAG_W > PC_W) begin : g_bad_tag
    $error("mt_btb: tag field exceeds PC width");
  end

  function automatic logic [IDX_W-1:0] set_of(input logic [PC_W-1:0] pc,
                                               input logic [TID_W-1:0] tid);
    logic [IDX_W-1:0] mix;
    mix = IDX_W'(tid) << TID_SHIFT;
    return pc[INST_SHIFT +: IDX_W] ^ mix;
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TID_W-1:0]   tid_q [ENTRIES];
  logic [TGT_W-1:0]   tgt_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             unused_pc_bits;

  assign lk_idx = set_of(lk_pc, lk_tid);
  assign up_idx = set_of(up_pc, up_tid);
  assign lk_tag = lk_pc[TAG_SHIFT +: TAG_W];
  assign unused_pc_bits = ^{lk_pc, up_pc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           valid_q <= '0;
    else if (flush)       valid_q <= '0;
    else if (up_en)       valid_q[up_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (up_en && !flush) begin
      tag_q[up_idx] <= up_pc[TAG_SHIFT +: TAG_W];
      tid_q[up_idx] <= up_tid;
      tgt_q[up_idx] <= up_target;
    end
  end

  assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && (tid_q[lk_idx] == lk_tid);
  assign lk_target = lk_hit ? tgt_q[lk_idx] : '0;
endmodule

// File: rtl/mt_btb_chk.sv
module mt_btb_chk #(
  parameter int PC_W       = 32,
  parameter int TGT_W      = 32,
  parameter int ENTRIES    = 16,
  parameter int TAG_W      = 8,
  parameter int THREADS    = 4,
  parameter int INST_SHIFT = 2,
  localparam int LOG2T     = $clog2(THREADS),
  localparam int TID_W     = (LOG2T > 0) ? LOG2T : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [PC_W-1:0]  lk_pc,
  input logic [TID_W-1:0] lk_tid,
  input logic             lk_hit,
  input logic [TGT_W-1:0] lk_target,
  input logic             up_en,
  input logic [PC_W-1:0]  up_pc,
  input logic [TID_W-1:0] up_tid,
  input logic [TGT_W-1:0] up_target
);
  AST_MISS_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_target == '0);  // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);  // R7

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !flush) |=>
      ((lk_pc == $past(up_pc) && lk_tid == $past(up_tid) && !$past(flush))
        -> (lk_hit && lk_target == $past(up_target))));  // R5

  AST_QUIET_TABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(up_en) && !$past(flush) && $stable(lk_pc) && $stable(lk_tid))
      |-> ($stable(lk_hit) && $stable(lk_target)));  // R6
endmodule

bind mt_btb mt_btb_chk #(
  .PC_W(PC_W), .TGT_W(TGT_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W),
  .THREADS(THREADS), .INST_SHIFT(INST_SHIFT)
) u_chk (.*);

// File: tb/tb_mt_btb.sv
module tb_mt_btb;
  localparam int PC_W = 32, TGT_W = 32, ENTRIES = 16, TAG_W = 8, THREADS = 4, INST_SHIFT = 2;
  localparam int IDX_W = 4, LOG2T = 2, TID_W = 2, TAG_SHIFT = INST_SHIFT + IDX_W;

  logic clk = 0, rst_n = 0, flush = 0, up_en = 0, lk_hit;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic [TID_W-1:0] lk_tid = '0, up_tid = '0;
  logic [TGT_W-1:0] lk_target, up_target = '0;
  int total = 0, bad = 0;

  mt_btb dut (.*);

  always #4 clk = ~clk;

  function automatic logic [PC_W-1:0] mkpc(int set, int tag, int tid, int hi = 0, int lo = 0);
    int raw;
    raw = (set ^ (tid << (IDX_W - LOG2T))) & (ENTRIES - 1);
    return (PC_W'(hi) << (TAG_SHIFT + TAG_W)) | (PC_W'(tag) << TAG_SHIFT)
         | (PC_W'(raw) << INST_SHIFT) | PC_W'(lo);
  endfunction

  task automatic check(input bit ok, input string req, input logic [TGT_W:0] act, input logic [TGT_W:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic expect_lk(input logic [PC_W-1:0] pc, input int tid, input bit hit,
                           input logic [TGT_W-1:0] tgt, input string req);
    lk_pc = pc; lk_tid = TID_W'(tid);
    #1;
    check(lk_hit === hit && lk_target === (hit ? tgt : '0), req,
          {lk_hit, lk_target}, {hit, hit ? tgt : {TGT_W{1'b0}}});
  endtask

  task automatic write(input logic [PC_W-1:0] pc, input int tid, input logic [TGT_W-1:0] tgt);
    @(negedge clk);
    up_en = 1; up_pc = pc; up_tid = TID_W'(tid); up_target = tgt;
    @(negedge clk);
    up_en = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    for (int s = 0; s < ENTRIES; s += 5) expect_lk(mkpc(s, 0, 0), 0, 0, '0, "R7 reset");
  endtask

  task automatic t_basic();
    write(mkpc(3, 8'h5A, 0), 0, 32'h1000_0040);
    expect_lk(mkpc(3, 8'h5A, 0), 0, 1, 32'h1000_0040, "R5 write then hit");
    expect_lk(mkpc(3, 8'h5B, 0), 0, 0, '0, "R3 tag mismatch");
    expect_lk(mkpc(3, 8'h5B, 0), 0, 0, '0, "R4 miss target zero");
    expect_lk(mkpc(3, 8'h5A, 0, 0, 3), 0, 1, 32'h1000_0040, "R2 low bits ignored");
    expect_lk(mkpc(3, 8'h5A, 0, 'h2A5), 0, 1, 32'h1000_0040, "R2 high bits ignored");
    write(mkpc(3, 8'h77, 0), 0, 32'h2222_0000);
    expect_lk(mkpc(3, 8'h77, 0), 0, 1, 32'h2222_0000, "R5 overwrite new");
    expect_lk(mkpc(3, 8'h5A, 0), 0, 0, '0, "R5 overwrite old gone");
  endtask

  task automatic t_threads();
    logic [PC_W-1:0] pc;
    do_flush();
    pc = mkpc(6, 8'h11, 0);
    write(pc, 0, 32'hAAAA_0000);
    // same PC, thread 1 goes to set 6^4=2: no eviction of thread 0
    write(pc, 1, 32'hBBBB_0000);
    expect_lk(pc, 0, 1, 32'hAAAA_0000, "R1 threads separate sets");
    expect_lk(pc, 1, 1, 32'hBBBB_0000, "R1 thread 1 hashed set");
    // thread 2 PC that maps to set 6 with same tag: must miss (stored thread 0)
    expect_lk(mkpc(6, 8'h11, 2), 2, 0, '0, "R3 thread mismatch");
    write(mkpc(6, 8'h11, 2), 2, 32'hCCCC_0000);
    expect_lk(pc, 0, 0, '0, "R1 alias evicts");
    expect_lk(mkpc(6, 8'h11, 2), 2, 1, 32'hCCCC_0000, "R1 alias writer hits");
  endtask

  task automatic t_same_cycle();
    logic [PC_W-1:0] pc;
    do_flush();
    pc = mkpc(9, 8'h3C, 3);
    @(negedge clk);
    up_en = 1; up_pc = pc; up_tid = 2'd3; up_target = 32'h0BAD_F00D;
    expect_lk(pc, 3, 0, '0, "R6 same cycle old contents");
    @(negedge clk);
    up_en = 0;
    expect_lk(pc, 3, 1, 32'h0BAD_F00D, "R6 next cycle new contents");
  endtask

  task automatic t_flush();
    write(mkpc(1, 8'h01, 0), 0, 32'h0000_1111);
    write(mkpc(12, 8'hF0, 1), 1, 32'h0000_2222);
    do_flush();
    expect_lk(mkpc(1, 8'h01, 0), 0, 0, '0, "R7 flush clears a");
    expect_lk(mkpc(12, 8'hF0, 1), 1, 0, '0, "R7 flush clears b");
    @(negedge clk);
    flush = 1; up_en = 1; up_pc = mkpc(4, 8'h44, 0); up_tid = 0; up_target = 32'h4444_4444;
    @(negedge clk);
    flush = 0; up_en = 0;
    expect_lk(mkpc(4, 8'h44, 0), 0, 0, '0, "R8 update under flush dropped");
  endtask

  task automatic t_zero_target();
    write(mkpc(15, 8'h99, 1), 1, '0);
    expect_lk(mkpc(15, 8'h99, 1), 1, 1, '0, "R9 zero target hit");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_threads();
    t_same_cycle();
    t_flush();
    t_zero_target();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule